// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block chooses the input channel for the next conversion frame of a multichannel converter. The serial front end decodes each frame's control word. At the end of the frame it raises a one-cycle frame-complete strobe, together with the write-enable bit, the two sequencing-mode bits and the channel address of that frame. The sequencer keeps the index of the channel to convert next, the last channel of a programmed cycle, and a flag that shows whether an automatic cycle is running.

There are three ways to use it. A write with the high mode bit clear picks one channel directly. A write with both mode bits set starts an automatic cycle: it begins at channel 0, moves up one channel per frame, and after the programmed last channel it goes back to 0. A write with the high mode bit set and the low mode bit clear lets the host rewrite other settings without breaking a running cycle. Frames without a write also leave a running cycle going.

Top module: `chan_sequencer`

## Requirements
- R1: After synchronous reset, next_ch is 0, seq_run is 0 and last_ch is 0.
- R2: A frame with wr_bit=1 and seq_hi=0, whatever seq_lo is, sets next_ch to the channel decoded from ch_addr (0 to 0, 1 to 1, 2 to 2, 3 to 3) and clears seq_run.
- R3: A frame with wr_bit=1, seq_hi=1 and seq_lo=1 sets seq_run, loads last_ch from ch_addr, and sets next_ch to 0.
- R4: While seq_run is 1, a frame with wr_bit=0 moves next_ch up by one and leaves last_ch and seq_run unchanged.
- R5: While seq_run is 1, a frame that advances the cycle when next_ch equals last_ch sets next_ch to 0.
- R6: While seq_run is 0, a frame with wr_bit=0 leaves next_ch, last_ch and seq_run unchanged.
- R7: While seq_run is 1, a frame with wr_bit=1, seq_hi=1 and seq_lo=0 advances the cycle the same way as R4 and R5, and ignores ch_addr.
- R8: While seq_run is 0, a frame with wr_bit=1, seq_hi=1 and seq_lo=0 selects ch_addr the same way as R2 and keeps seq_run at 0.
- R9: In cycles where frame_done is 0, next_ch, last_ch and seq_run do not change.
- R10: A start write (R3) that arrives while a cycle is running restarts at channel 0 with the new last channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_done | input | 1 | One-cycle strobe at the end of a frame |
| wr_bit | input | 1 | Write-enable bit of the frame's control word |
| seq_hi | input | 1 | High sequencing-mode bit |
| seq_lo | input | 1 | Low sequencing-mode bit |
| ch_addr | input | CH_W | Channel address field of the control word |
| next_ch | output | CH_W | Channel to convert on the next frame |
| seq_run | output | 1 | Automatic cycle is active |
| last_ch | output | CH_W | Last channel of the programmed cycle |

## Verification
The hardest case to reach is a wrap from the last channel that happens on a keep-running write (R7 together with R5), ideally right after a restart with a small last channel. To reach it, the random stimulus favours start writes with low addresses and many no-write and keep-running frames, so cycles are short and wrap often. Directed sequences also place a keep-running write exactly on the last channel and issue a restart partway through a cycle.

// File: rtl/chseq_pkg.sv
package chseq_pkg;
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_HOLD,
        CMD_SINGLE,
        CMD_START,
        CMD_CONT
    } seq_cmd_e;
endpackage

// File: rtl/chseq_decode.sv
module chseq_decode
    import chseq_pkg::*;
(
    input  logic     frame_done,
    input  logic     wr_bit,
    input  logic     seq_hi,
    input  logic     seq_lo,
    output seq_cmd_e cmd
);
    always_comb begin
        if (!frame_done)  cmd = CMD_NONE;
        else if (!wr_bit) cmd = CMD_HOLD;
        else if (!seq_hi) cmd = CMD_SINGLE;
        else if (seq_lo)  cmd = CMD_START;
        else              cmd = CMD_CONT;
    end
endmodule

// File: rtl/chseq_state.sv
module chseq_state
    import chseq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  seq_cmd_e        cmd,
    input  logic [CH_W-1:0] addr,
    output logic [CH_W-1:0] ch,
    output logic            run,
    output logic [CH_W-1:0] last
);
    localparam logic [CH_W-1:0] MAX_CH = CH_W'(NUM_CH - 1);

    logic [CH_W-1:0] addr_c;
    logic [CH_W-1:0] adv;

    assign addr_c = (addr > MAX_CH) ? MAX_CH : addr;
    assign adv    = (ch == last) ? '0 : ch + CH_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ch   <= '0;
            run  <= 1'b0;
            last <= '0;
        end else begin
            case (cmd)
                CMD_HOLD: begin
                    if (run) ch <= adv;
                end
                CMD_CONT: begin
                    if (run) ch <= adv;
                    else     ch <= addr_c;
                end
                CMD_SINGLE: begin
                    run <= 1'b0;
                    ch  <= addr_c;
                end
                CMD_START: begin
                    run  <= 1'b1;
                    last <= addr_c;
                    ch   <= '0;
                end
                default: ;
            endcase
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (ch == '0 && !run && last == '0)); // R1
    AST_SINGLE_SEL: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_SINGLE |=> (!run && ch == $past(addr_c))); // R2
    AST_START: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_START |=> (run && ch == '0 && last == $past(addr_c))); // R3
    AST_RUN_KEEP: assert property (@(posedge clk) disable iff (rst)
        (run && (cmd == CMD_HOLD || cmd == CMD_CONT)) |=> (run && $stable(last))); // R4
    AST_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run && ch == last && (cmd == CMD_HOLD || cmd == CMD_CONT)) |=> ch == '0); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && cmd == CMD_HOLD) |=> ($stable(ch) && !run)); // R6
    AST_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_NONE |=> ($stable(ch) && $stable(run) && $stable(last))); // R9
    AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        run |-> ch <= last); // R5
endmodule

// File: rtl/chan_sequencer.sv
module chan_sequencer
    import chseq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            frame_done,
    input  logic            wr_bit,
    input  logic            seq_hi,
    input  logic            seq_lo,
    input  logic [CH_W-1:0] ch_addr,
    output logic [CH_W-1:0] next_ch,
    output logic            seq_run,
    output logic [CH_W-1:0] last_ch
);
    seq_cmd_e cmd;

    chseq_decode u_dec (
        .frame_done (frame_done),
        .wr_bit     (wr_bit),
        .seq_hi     (seq_hi),
        .seq_lo     (seq_lo),
        .cmd        (cmd)
    );

    chseq_state #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_st (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .addr (ch_addr),
        .ch   (next_ch),
        .run  (seq_run),
        .last (last_ch)
    );
endmodule

// File: tb/sim_chan_sequencer.sv
module sim_chan_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int CH_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_done = 1'b0, wr_bit = 1'b0, seq_hi = 1'b0, seq_lo = 1'b0;
    logic [CH_W-1:0] ch_addr = '0;
    logic [CH_W-1:0] next_ch, last_ch;
    logic seq_run;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int m_ch = 0, m_last = 0;
    bit m_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_sequencer #(.NUM_CH(4)) u0 (
        .clk(clk), .rst(rst), .frame_done(frame_done), .wr_bit(wr_bit),
        .seq_hi(seq_hi), .seq_lo(seq_lo), .ch_addr(ch_addr),
        .next_ch(next_ch), .seq_run(seq_run), .last_ch(last_ch)
    );

    function automatic int advance(int c, int l);
        return (c == l) ? 0 : c + 1;
    endfunction

    task automatic check(string req);
        total++;
        if (int'(next_ch) != m_ch || seq_run != m_run || int'(last_ch) != m_last) begin
            bad++;
            $display("FAIL %s: got ch=%0d run=%0d last=%0d exp ch=%0d run=%0d last=%0d",
                     req, next_ch, seq_run, last_ch, m_ch, m_run, m_last);
        end
    endtask

    // applies one frame, updates model, checks after the capturing edge
    task automatic frame(bit w, bit h, bit l, int a);
        string req;
        @(negedge clk);
        frame_done = 1'b1; wr_bit = w; seq_hi = h; seq_lo = l; ch_addr = CH_W'(a);
        if (!w) begin
            if (m_run) begin req = (m_ch == m_last) ? "R5" : "R4"; m_ch = advance(m_ch, m_last); end
            else req = "R6";
        end else if (!h) begin
            req = "R2"; m_ch = a; m_run = 0;
        end else if (l) begin
            req = m_run ? "R10" : "R3"; m_run = 1; m_last = a; m_ch = 0;
        end else if (m_run) begin
            req = "R7"; m_ch = advance(m_ch, m_last);
        end else begin
            req = "R8"; m_ch = a;
        end
        @(negedge clk);
        frame_done = 1'b0;
        check(req);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_bit = $urandom_range(0, 1); seq_hi = $urandom_range(0, 1);
            seq_lo = $urandom_range(0, 1); ch_addr = CH_W'($urandom_range(0, 3));
        end
        check("R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: got hang exp finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1");
        // R6 idle no-write frame
        frame(0, 0, 0, 3);
        // R2 every address decode
        for (int a = 0; a < 4; a++) frame(1, 0, a % 2, a);
        // R8 keep-running write when idle
        frame(1, 1, 0, 2);
        // R3 start with last=2, then R4/R5 cycle
        frame(1, 1, 1, 2);
        for (int i = 0; i < 5; i++) frame(0, 0, 0, 1);
        // R7 on last channel wraps
        frame(1, 1, 1, 1);
        frame(1, 1, 0, 3);
        frame(1, 1, 0, 0);
        // R10 restart mid-cycle
        frame(1, 1, 1, 3);
        frame(0, 0, 0, 0);
        frame(0, 0, 0, 0);
        frame(1, 1, 1, 0);
        frame(0, 0, 0, 2);
        idle(4);
        // exit back to single mode
        frame(1, 0, 1, 1);
        idle(3);
        // random mix, weighted toward short cycles
        for (int i = 0; i < 400; i++) begin
            int r = $urandom_range(0, 9);
            case (r)
                0:       frame(1, 0, $urandom_range(0, 1), $urandom_range(0, 3));
                1:       frame(1, 1, 1, $urandom_range(0, 1));
                2:       frame(1, 1, 1, $urandom_range(0, 3));
                3, 4:    frame(1, 1, 0, $urandom_range(0, 3));
                9:       idle($urandom_range(1, 3));
                default: frame(0, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3));
            endcase
        end
        // reset again mid-cycle
        frame(1, 1, 1, 3);
        frame(0, 0, 0, 0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_ch = 0; m_run = 0; m_last = 0;
        check("R1");
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule